// File: doc/BRIEF.md
# SD/MMC Host Register and Interrupt Frontend

This block is the software-visible face of a simple SD/MMC host controller. A 32-bit register bus writes the transfer setup (buffer address, command argument, block size and block count) and then launches a command by writing a packed command word. The block decodes that word into separate fields for the card-side engine, and gives the engine a one-cycle start pulse together with the argument value captured at launch.

When the engine finishes, the block captures the card's response into four readable words. A 136-bit response fills all four words. A short response fills only the first word. The engine also reports data completion and command timeout. Card presence and write-protect arrive as asynchronous pins and are resynchronised; any change of either one is also treated as an event. Events are held in a status register that software clears by writing ones, and a level interrupt is raised while any held event is also enabled.

Top module: `mmc_host_regs`

## Requirements
- R1: After reset, status, enable, command word, argument, buffer address, block fields and all response words read zero, the interrupt is low and no start pulse is given.
- R2: Registers sit at byte offsets status 0x00, enable 0x04, buffer address 0x08, command 0x0C, argument 0x10, responses 0x14/0x18/0x1C/0x20, block length 0x24, block count 0x28, card state 0x2C. Enable, buffer address and argument read back as written. Unaligned or unmapped offsets read zero. A read returns data one cycle after the request, flagged by the read-valid output.
- R3: A command write while idle gives a start pulse of exactly one cycle in the next cycle. The word is decoded as opcode bits 5:0, open-drain bit 6, response kind bits 9:8 (0 none, 1 short, 2 long 136-bit, 3 short without CRC), busy-wait bit 11, command class bits 13:12 and read direction bit 15.
- R4: A command write while a command is in flight is ignored. It gives no start pulse, leaves the command word unchanged and sets no status bit.
- R5: The engine argument is the argument register value at the moment of the command write. Later writes to the argument register do not change it.
- R6: On engine completion, the status bit for end of command (bit 0) and the response words update at the same clock edge. Response kind 2 loads 0x14..0x20 with response bits 31:0, 63:32, 95:64 and 127:96. Kinds 1 and 3 load 0x14 with bits 31:0 and zero the other three words. Kind 0 zeroes all four. The words then hold until the next completion.
- R7: A command timeout sets only status bit 3 and never bit 0, even when completion is reported in the same cycle. It ends the in-flight command and leaves the response words unchanged.
- R8: Engine data completion sets status bit 2's neighbour, bit 1.
- R9: Card state reads bit 0 inserted and bit 1 write-protected, each through a two-flop synchronizer. Any change of either bit sets status bit 2.
- R10: Writing a value to status clears exactly the bits that are one in it. An event arriving in the same cycle as its clear leaves the bit set.
- R11: The interrupt is high while status AND enable is nonzero. Writing zero to enable lowers it without clearing status.
- R12: Block length and count are 11-bit fields holding the value minus one. Upper write bits are dropped, and the engine receives field+1 (1..2048).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd_en |
| irq_o | output | 1 | Level interrupt |
| eng_cmd_start_o | output | 1 | One-cycle command launch |
| eng_opcode_o | output | 6 | Decoded opcode |
| eng_rsp_kind_o | output | 2 | Decoded response kind |
| eng_open_drain_o | output | 1 | Open-drain bus mode flag |
| eng_busy_wait_o | output | 1 | Busy-wait after response flag |
| eng_cmd_class_o | output | 2 | Command class |
| eng_read_dir_o | output | 1 | Data direction is card to host |
| eng_cmd_arg_o | output | 32 | Argument captured at launch |
| eng_buf_addr_o | output | 32 | Buffer address |
| eng_blk_len_o | output | BLK_W+1 | Block length in bytes |
| eng_blk_cnt_o | output | BLK_W+1 | Number of blocks |
| eng_cmd_done_i | input | 1 | Engine: command finished |
| eng_cmd_timeout_i | input | 1 | Engine: command timed out |
| eng_data_done_i | input | 1 | Engine: data phase finished |
| eng_resp_i | input | 128 | Engine: response bits |
| card_present_i | input | 1 | Asynchronous card-inserted pin |
| card_wp_i | input | 1 | Asynchronous write-protect pin |

## Verification
The bench builds the block with its default parameters: a 6-bit byte offset and 11-bit block fields. With these values the all-ones field gives the 2048 upper limit, and an all-ones write above bit 10 shows that the upper bits are dropped. The two-stage synchronizer keeps card-detect latency short, so a change of either pin is seen in status within a few cycles. The engine is modelled by the bench, which makes it possible to report timeout and completion in the same cycle and to send a clear and a new event together.

// File: rtl/mmc_regs_pkg.sv
package mmc_regs_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_RESP = 4;
  localparam int unsigned NUM_EVT  = 4;

  // event bit positions inside the status register
  localparam int unsigned EVT_CMD  = 0;
  localparam int unsigned EVT_DATA = 1;
  localparam int unsigned EVT_CARD = 2;
  localparam int unsigned EVT_TMO  = 3;

  typedef enum logic [3:0] {
    SEL_STATUS = 4'd0,
    SEL_ENABLE = 4'd1,
    SEL_BUFADR = 4'd2,
    SEL_CMD    = 4'd3,
    SEL_ARG    = 4'd4,
    SEL_RESP0  = 4'd5,
    SEL_RESP1  = 4'd6,
    SEL_RESP2  = 4'd7,
    SEL_RESP3  = 4'd8,
    SEL_BLKLEN = 4'd9,
    SEL_BLKCNT = 4'd10,
    SEL_CARD   = 4'd11,
    SEL_NONE   = 4'd15
  } reg_sel_e;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_SHORT  = 2'd1,
    RSP_LONG   = 2'd2,
    RSP_NOCRC  = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic            read_dir;
    logic [1:0]      cmd_class;
    logic            busy_wait;
    rsp_kind_e       rsp_kind;
    logic            open_drain;
    logic [5:0]      opcode;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_cmd(input logic [WORD_W-1:0] w);
    cmd_fields_t f;
    f.opcode     = w[5:0];
    f.open_drain = w[6];
    f.rsp_kind   = rsp_kind_e'(w[9:8]);
    f.busy_wait  = w[11];
    f.cmd_class  = w[13:12];
    f.read_dir   = w[15];
    return f;
  endfunction

  function automatic reg_sel_e sel_from_index(input logic [3:0] idx, input logic valid);
    if (!valid || idx > 4'd11) return SEL_NONE;
    return reg_sel_e'(idx);
  endfunction

  // whether response word idx is loaded from the engine for a given kind
  function automatic logic resp_word_used(input rsp_kind_e kind, input int unsigned idx);
    case (kind)
      RSP_LONG:             return 1'b1;
      RSP_SHORT, RSP_NOCRC: return (idx == 0);
      default:              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mmc_card_sync.sv
module mmc_card_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] state_o,
  output logic             change_o
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= pins_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign state_o  = chain_q[STAGES-1];
  assign change_o = (chain_q[STAGES-1] != prev_q);

  // R9: a reported change is followed by a settled state unless the pins move again
  assert_change_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |=> (prev_q == $past(state_o)));

endmodule

// File: rtl/mmc_evt_status.sv
module mmc_evt_status
  import mmc_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic               clr_wr_i,
  input  logic [NUM_EVT-1:0] clr_mask_i,
  input  logic               en_wr_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  output logic [NUM_EVT-1:0] status_o,
  output logic [NUM_EVT-1:0] enable_o,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] status_q, enable_q, clr_eff;

  assign clr_eff = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_eff) | set_i;
      if (en_wr_i) enable_q <= en_wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);

  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && set_i == '0) |=> ((status_q & $past(clr_mask_i)) == '0));

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  assert_enable_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(enable_q));

endmodule

// File: rtl/mmc_cmd_launch.sv
module mmc_cmd_launch
  import mmc_regs_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_wr_i,
  input  logic [WORD_W-1:0]          cmd_wdata_i,
  input  logic [WORD_W-1:0]          arg_i,
  input  logic                       eng_done_i,
  input  logic                       eng_tmo_i,
  input  logic [NUM_RESP*WORD_W-1:0] eng_resp_i,
  output logic [WORD_W-1:0]          cmd_word_o,
  output logic [WORD_W-1:0]          cmd_arg_o,
  output logic                       start_o,
  output logic [NUM_RESP-1:0][WORD_W-1:0] resp_o,
  output logic                       ev_end_o,
  output logic                       ev_tmo_o
);

  logic              busy_q, start_q;
  logic [WORD_W-1:0] cmd_word_q, cmd_arg_q;
  logic [NUM_RESP-1:0][WORD_W-1:0] resp_q;
  logic              accept, ev_end, ev_tmo;
  cmd_fields_t       cur;

  assign cur    = unpack_cmd(cmd_word_q);
  assign accept = cmd_wr_i && !busy_q;
  assign ev_tmo = busy_q && eng_tmo_i;
  assign ev_end = busy_q && eng_done_i && !eng_tmo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      cmd_word_q <= '0;
      cmd_arg_q  <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q     <= 1'b1;
        cmd_word_q <= cmd_wdata_i;
        cmd_arg_q  <= arg_i;
      end else if (ev_end || ev_tmo) begin
        busy_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_RESP; i++) begin : g_resp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resp_q[i] <= '0;
      else if (ev_end)
        resp_q[i] <= resp_word_used(cur.rsp_kind, i) ? eng_resp_i[i*WORD_W +: WORD_W] : '0;
    end
  end

  assign cmd_word_o = cmd_word_q;
  assign cmd_arg_o  = cmd_arg_q;
  assign start_o    = start_q;
  assign resp_o     = resp_q;
  assign ev_end_o   = ev_end;
  assign ev_tmo_o   = ev_tmo;

  assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> start_q);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_wr_i) |=> ($stable(cmd_word_q) && !start_q));

  assert_arg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cmd_arg_q) || start_q);

  assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_end |=> $stable(resp_q));

endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
  import mmc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BLK_W  = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr_en,
  input  logic                        bus_rd_en,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  output logic                        irq_o,
  output logic                        eng_cmd_start_o,
  output logic [5:0]                  eng_opcode_o,
  output logic [1:0]                  eng_rsp_kind_o,
  output logic                        eng_open_drain_o,
  output logic                        eng_busy_wait_o,
  output logic [1:0]                  eng_cmd_class_o,
  output logic                        eng_read_dir_o,
  output logic [31:0]                 eng_cmd_arg_o,
  output logic [31:0]                 eng_buf_addr_o,
  output logic [BLK_W:0]              eng_blk_len_o,
  output logic [BLK_W:0]              eng_blk_cnt_o,
  input  logic                        eng_cmd_done_i,
  input  logic                        eng_cmd_timeout_i,
  input  logic                        eng_data_done_i,
  input  logic [127:0]                eng_resp_i,
  input  logic                        card_present_i,
  input  logic                        card_wp_i
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  function automatic logic [BLK_W:0] span_of(input logic [BLK_W-1:0] field);
    return {1'b0, field} + 1'b1;
  endfunction

  // address decode
  logic [IDX_W-1:0] word_idx;
  logic             idx_ok;
  reg_sel_e         sel;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign idx_ok   = (bus_addr[1:0] == 2'b00) && (word_idx < IDX_W'(12));
  assign sel      = sel_from_index(word_idx[3:0], idx_ok);

  // plain setup registers
  logic [WORD_W-1:0] buf_addr_q, arg_q;
  logic [BLK_W-1:0]  blk_len_q, blk_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr_q <= '0;
      arg_q      <= '0;
      blk_len_q  <= '0;
      blk_cnt_q  <= '0;
    end else if (bus_wr_en) begin
      case (sel)
        SEL_BUFADR: buf_addr_q <= bus_wdata;
        SEL_ARG:    arg_q      <= bus_wdata;
        SEL_BLKLEN: blk_len_q  <= bus_wdata[BLK_W-1:0];
        SEL_BLKCNT: blk_cnt_q  <= bus_wdata[BLK_W-1:0];
        default: ;
      endcase
    end
  end

  // command launch and response capture
  logic [WORD_W-1:0]               cmd_word;
  logic [NUM_RESP-1:0][WORD_W-1:0] resp;
  logic                            ev_end, ev_tmo;
  cmd_fields_t                     fields;

  mmc_cmd_launch u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (bus_wr_en && sel == SEL_CMD),
    .cmd_wdata_i (bus_wdata),
    .arg_i       (arg_q),
    .eng_done_i  (eng_cmd_done_i),
    .eng_tmo_i   (eng_cmd_timeout_i),
    .eng_resp_i  (eng_resp_i),
    .cmd_word_o  (cmd_word),
    .cmd_arg_o   (eng_cmd_arg_o),
    .start_o     (eng_cmd_start_o),
    .resp_o      (resp),
    .ev_end_o    (ev_end),
    .ev_tmo_o    (ev_tmo)
  );

  assign fields           = unpack_cmd(cmd_word);
  assign eng_opcode_o     = fields.opcode;
  assign eng_rsp_kind_o   = fields.rsp_kind;
  assign eng_open_drain_o = fields.open_drain;
  assign eng_busy_wait_o  = fields.busy_wait;
  assign eng_cmd_class_o  = fields.cmd_class;
  assign eng_read_dir_o   = fields.read_dir;

  // card detect
  logic [1:0] card_state;
  logic       card_change;

  mmc_card_sync #(.STAGES(2), .WIDTH(2)) u_card (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_i   ({card_wp_i, card_present_i}),
    .state_o  (card_state),
    .change_o (card_change)
  );

  // event status and interrupt
  logic [NUM_EVT-1:0] evt_set, evt_status, evt_enable;

  always_comb begin
    evt_set           = '0;
    evt_set[EVT_CMD]  = ev_end;
    evt_set[EVT_DATA] = eng_data_done_i;
    evt_set[EVT_CARD] = card_change;
    evt_set[EVT_TMO]  = ev_tmo;
  end

  mmc_evt_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_wr_i   (bus_wr_en && sel == SEL_STATUS),
    .clr_mask_i (bus_wdata[NUM_EVT-1:0]),
    .en_wr_i    (bus_wr_en && sel == SEL_ENABLE),
    .en_wdata_i (bus_wdata[NUM_EVT-1:0]),
    .status_o   (evt_status),
    .enable_o   (evt_enable),
    .irq_o      (irq_o)
  );

  // registered read port
  logic [31:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_STATUS: rd_mux = 32'(evt_status);
      SEL_ENABLE: rd_mux = 32'(evt_enable);
      SEL_BUFADR: rd_mux = buf_addr_q;
      SEL_CMD:    rd_mux = cmd_word;
      SEL_ARG:    rd_mux = arg_q;
      SEL_RESP0:  rd_mux = resp[0];
      SEL_RESP1:  rd_mux = resp[1];
      SEL_RESP2:  rd_mux = resp[2];
      SEL_RESP3:  rd_mux = resp[3];
      SEL_BLKLEN: rd_mux = 32'(blk_len_q);
      SEL_BLKCNT: rd_mux = 32'(blk_cnt_q);
      SEL_CARD:   rd_mux = 32'(card_state);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end

  assign eng_buf_addr_o = buf_addr_q;
  assign eng_blk_len_o  = span_of(blk_len_q);
  assign eng_blk_cnt_o  = span_of(blk_cnt_q);

  assert_tmo_no_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_timeout_i |=> !$rose(evt_status[EVT_CMD]));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel == SEL_ENABLE && bus_wdata[NUM_EVT-1:0] == '0) |=> !irq_o);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rvalid);

endmodule

// File: tb/test_mmc_host_regs.sv
module test_mmc_host_regs;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid, irq_o, eng_cmd_start_o;
  logic [5:0]   eng_opcode_o;
  logic [1:0]   eng_rsp_kind_o, eng_cmd_class_o;
  logic         eng_open_drain_o, eng_busy_wait_o, eng_read_dir_o;
  logic [31:0]  eng_cmd_arg_o, eng_buf_addr_o;
  logic [11:0]  eng_blk_len_o, eng_blk_cnt_o;
  logic         eng_cmd_done_i = 1'b0, eng_cmd_timeout_i = 1'b0, eng_data_done_i = 1'b0;
  logic [127:0] eng_resp_i = '0;
  logic         card_present_i = 1'b0, card_wp_i = 1'b0;

  int errors = 0;
  int checks = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mmc_host_regs i_mmc_host_regs (.*);

  localparam logic [31:0] W0 = 32'h0A0B0C0D, W1 = 32'h11223344,
                          W2 = 32'h55667788, W3 = 32'h99AABBCC;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic engine(input logic done, input logic tmo, input logic data, input logic [127:0] r);
    @(negedge clk);
    eng_cmd_done_i = done; eng_cmd_timeout_i = tmo; eng_data_done_i = data; eng_resp_i = r;
    @(negedge clk);
    eng_cmd_done_i = 1'b0; eng_cmd_timeout_i = 1'b0; eng_data_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(32'(irq_o), 0, "R1 irq");
    check(32'(eng_cmd_start_o), 0, "R1 start");
    bus_read(6'h00, 0, "R1 status");
    bus_read(6'h04, 0, "R1 enable");
    bus_read(6'h0C, 0, "R1 cmd");
    bus_read(6'h24, 0, "R1 blklen");
    bus_read(6'h14, 0, "R1 resp0");
    bus_read(6'h20, 0, "R1 resp3");

    // R2 map and readback
    bus_write(6'h08, 32'hDEADBEE0);
    bus_write(6'h10, 32'h12345678);
    bus_write(6'h04, 32'hF);
    bus_read(6'h08, 32'hDEADBEE0, "R2 bufaddr");
    bus_read(6'h10, 32'h12345678, "R2 arg");
    bus_read(6'h04, 32'hF, "R2 enable");
    bus_read(6'h30, 0, "R2 unmapped");
    bus_read(6'h0A, 0, "R2 unaligned");
    check(eng_buf_addr_o, 32'hDEADBEE0, "R2 buf out");

    // R3 launch and decode
    bus_write(6'h0C, 32'h0000B951);
    check(32'(eng_cmd_start_o), 1, "R3 start pulse");
    check(32'(eng_opcode_o), 17, "R3 opcode");
    check(32'(eng_open_drain_o), 1, "R3 open drain");
    check(32'(eng_rsp_kind_o), 1, "R3 rsp kind");
    check(32'(eng_busy_wait_o), 1, "R3 busy wait");
    check(32'(eng_cmd_class_o), 3, "R3 class");
    check(32'(eng_read_dir_o), 1, "R3 read dir");
    check(eng_cmd_arg_o, 32'h12345678, "R5 arg at launch");
    @(negedge clk);
    check(32'(eng_cmd_start_o), 0, "R3 pulse ends");

    // R5 later arg write, R4 ignored command write
    bus_write(6'h10, 32'hAAAA0000);
    check(eng_cmd_arg_o, 32'h12345678, "R5 arg held");
    bus_write(6'h0C, 32'h00000002);
    check(32'(eng_cmd_start_o), 0, "R4 no start");
    bus_read(6'h0C, 32'h0000B951, "R4 cmd unchanged");
    bus_read(6'h00, 0, "R4 no status");

    // R6 short response
    engine(1, 0, 0, {W3, W2, W1, W0});
    check(32'(irq_o), 1, "R11 irq on end");
    bus_read(6'h00, 32'h1, "R6 end of command");
    bus_read(6'h14, W0, "R6 short word0");
    bus_read(6'h18, 0, "R6 short word1 zero");
    bus_write(6'h00, 32'h1);
    bus_read(6'h00, 0, "R10 cleared");
    check(32'(irq_o), 0, "R11 irq low");

    // R6 long response
    bus_write(6'h0C, 32'h00000202);
    engine(1, 0, 0, {W3, W2, W1, W0});
    bus_read(6'h14, W0, "R6 long 31:0");
    bus_read(6'h18, W1, "R6 long 63:32");
    bus_read(6'h1C, W2, "R6 long 95:64");
    bus_read(6'h20, W3, "R6 long 127:96");
    bus_write(6'h00, 32'hF);

    // R7 timeout together with done
    bus_write(6'h0C, 32'h00000105);
    engine(1, 1, 0, ~{W3, W2, W1, W0});
    bus_read(6'h00, 32'h8, "R7 timeout only");
    bus_read(6'h14, W0, "R7 resp kept");
    bus_write(6'h00, 32'h8);
    bus_write(6'h0C, 32'h00000000);
    check(32'(eng_cmd_start_o), 1, "R7 idle after timeout");
    engine(1, 0, 0, {W3, W2, W1, W0});
    bus_read(6'h14, 0, "R6 no-response kind zero");
    bus_write(6'h00, 32'hF);

    // R8 data done, R10 set wins over clear
    engine(0, 0, 1, '0);
    bus_read(6'h00, 32'h2, "R8 end of data");
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h2; eng_data_done_i = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; eng_data_done_i = 1'b0;
    bus_read(6'h00, 32'h2, "R10 event wins");

    // R11 mask
    bus_write(6'h04, 32'h0);
    check(32'(irq_o), 0, "R11 masked");
    bus_read(6'h00, 32'h2, "R11 status kept");
    bus_write(6'h04, 32'hF);
    check(32'(irq_o), 1, "R11 unmasked");
    bus_write(6'h00, 32'hF);

    // R9 card state
    @(negedge clk); card_present_i = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(6'h2C, 32'h1, "R9 inserted");
    bus_read(6'h00, 32'h4, "R9 change");
    bus_write(6'h00, 32'h4);
    @(negedge clk); card_wp_i = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(6'h2C, 32'h3, "R9 write protect");
    bus_read(6'h00, 32'h4, "R9 change wp");
    bus_write(6'h00, 32'h4);

    // R12 block fields
    bus_write(6'h24, 32'h7FF);
    check(32'(eng_blk_len_o), 2048, "R12 len max");
    bus_read(6'h24, 32'h7FF, "R12 len field");
    bus_write(6'h28, 32'hFFFFF800);
    check(32'(eng_blk_cnt_o), 1, "R12 upper dropped");
    bus_read(6'h28, 0, "R12 cnt field");
    bus_write(6'h28, 32'h1FF);
    check(32'(eng_blk_cnt_o), 512, "R12 cnt 512");

    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 0, "R2 all reads returned");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule